// File: doc/BRIEF.md
# Dual-Accumulator Pipelined MAC Unit

The unit multiplies the low 20 bits of two signed operands and adds the sign-extended 40-bit product into one of two 64-bit accumulators, A or B. It can take a new multiply-accumulate on every clock. Each multiplier needs two clocks to settle. To keep that rate, successive multiplies go to two multiplier lanes in turn. Each lane holds its operands for two clocks before its product is added in.

The issuing logic sends one command per cycle on a command port. A command is taken in a cycle where `cmd_valid_i` is high and `stall_o` is low. The unit can also:
- clear an accumulator, or both;
- load an accumulator from two 32-bit words;
- normalise one accumulator, or both with a shared shift, into a 32-bit mantissa plus a shift count ("fit");
- read an accumulator through a single 32-bit port, low word first, then high word.

Reads and fits wait for multiplies still in flight. The stall output tells the issuer when to hold a command.

Top module: `mac_dual_acc`

## Requirements
- R1: Command codes on `cmd_op_i` are: 0 no-op, 1 MAC into A, 2 MAC into B, 3 clear A, 4 clear B, 5 clear both, 6 load A, 7 load B, 8 fit A, 9 fit B, 10 fit both, 11 read A, 12 read B. Code 0 never stalls and changes nothing.
- R2: A MAC adds the signed product of operand bits [19:0] of `opd_a_i` and `opd_b_i` into the chosen accumulator, modulo 2^64. Operand bits [31:20] have no effect.
- R3: MAC commands are accepted on consecutive cycles without stalling, unless a fit is in its second cycle.
- R4: After reset both accumulators read zero and `busy_o` is low.
- R5: Clear commands set the targeted accumulator(s) to zero.
- R6: A load puts `opd_a_i` into the low word and `opd_b_i` into the high word of the targeted accumulator.
- R7: A fit applies the smallest arithmetic right shift (0..32) after which the value fits in 32 signed bits. It then leaves the shifted low 32 bits in the low word and the shift count, zero-extended, in the high word.
- R8: A joint fit shifts both accumulators by one count, the larger of the two individual counts.
- R9: A fit is held until 2 cycles after the last MAC was taken, so a fit directly after a MAC stalls 2 cycles. The cycle after a fit is taken, every non-zero command stalls.
- R10: A read returns the low word. If the low word has already been read and no MAC, clear, load or fit has since targeted that accumulator, a read returns the high word.
- R11: Reads, clears, loads and fits stall while any MAC is in flight; a read directly after a MAC stalls 2 cycles. Read data is presented on `rd_data_o` with `rd_valid_o` high in the cycle the read is taken.
- R12: `busy_o` is high while a MAC is in flight or a fit is in its second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 4 | Command code (R1) |
| opd_a_i | input | 32 | First operand / low word for loads |
| opd_b_i | input | 32 | Second operand / high word for loads |
| stall_o | output | 1 | Command cannot be taken this cycle |
| busy_o | output | 1 | MAC pipeline or fit in progress |
| rd_valid_o | output | 1 | Read data valid this cycle |
| rd_data_o | output | 32 | Read data |

## Verification
The bench builds the unit with its default values: 32-bit words, 20-bit multiplier inputs and 64-bit accumulators. The 6-bit shift count can therefore reach its maximum of 32, and the fit boundary at bit 31 is reachable through loads. With two lanes, back-to-back streams of random MACs send every product through both lanes in alternation. The accumulators are driven past 32 bits, so fit and high-word reads see real carries into the upper word.

// File: rtl/mac_dual_acc_pkg.sv
package mac_dual_acc_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_MAC_A  = 4'd1,
    OP_MAC_B  = 4'd2,
    OP_CLR_A  = 4'd3,
    OP_CLR_B  = 4'd4,
    OP_CLR_AB = 4'd5,
    OP_SET_A  = 4'd6,
    OP_SET_B  = 4'd7,
    OP_FIT_A  = 4'd8,
    OP_FIT_B  = 4'd9,
    OP_FIT_AB = 4'd10,
    OP_RD_A   = 4'd11,
    OP_RD_B   = 4'd12
  } mac_op_e;
endpackage

// File: rtl/mac_dual_acc_lane.sv
// One two-cycle multiplier lane: operands held for two clocks, product consumed at age 2.
module mac_dual_acc_lane #(
  parameter int DW    = 32,
  parameter int MUL_W = 20,
  parameter int ACC_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic             sel_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             sel_o,
  output logic [ACC_W-1:0] prod_o
);
  localparam int PW = 2 * MUL_W;

  logic [MUL_W-1:0] a_q, b_q;
  logic             sel_q;
  logic [1:0]       age_q;
  logic signed [PW-1:0] a_x, b_x, prod;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      sel_q <= 1'b0;
      age_q <= 2'd0;
    end else if (load_i) begin
      a_q   <= a_i[MUL_W-1:0];
      b_q   <= b_i[MUL_W-1:0];
      sel_q <= sel_i;
      age_q <= 2'd1;
    end else if (age_q == 2'd1) begin
      age_q <= 2'd2;
    end else begin
      age_q <= 2'd0;
    end
  end

  assign a_x    = PW'($signed(a_q));
  assign b_x    = PW'($signed(b_q));
  assign prod   = a_x * b_x;
  assign prod_o = ACC_W'(prod);
  assign busy_o = (age_q != 2'd0);
  assign done_o = (age_q == 2'd2);
  assign sel_o  = sel_q;
endmodule

// File: rtl/mac_dual_acc_fit.sv
// Shift count needed to squeeze a signed accumulator into DW bits.
module mac_dual_acc_fit #(
  parameter int DW    = 32,
  parameter int ACC_W = 64,
  parameter int EXP_W = 6
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic [EXP_W-1:0] shamt_o
);
  always_comb begin
    int   run;
    int   need;
    logic stop;
    run  = 0;
    stop = 1'b0;
    for (int i = ACC_W - 1; i >= 0; i--) begin
      if (!stop && (acc_i[i] == acc_i[ACC_W-1])) run = run + 1;
      else stop = 1'b1;
    end
    need = ACC_W - run + 1;  // significant bits incl. sign
    if (need > DW) shamt_o = EXP_W'(need - DW);
    else           shamt_o = '0;
  end
endmodule

// File: rtl/mac_dual_acc.sv
module mac_dual_acc
  import mac_dual_acc_pkg::*;
#(
  parameter int DW    = 32,
  parameter int MUL_W = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [3:0]    cmd_op_i,
  input  logic [DW-1:0] opd_a_i,
  input  logic [DW-1:0] opd_b_i,
  output logic          stall_o,
  output logic          busy_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int ACC_W  = 2 * DW;
  localparam int EXP_W  = $clog2(DW + 1);
  localparam int NLANE  = 2;
  localparam int NACC   = 2;

  mac_op_e op;
  logic    is_mac, is_rd, is_fit, take, mac_inflight;
  logic    rd_sel;

  logic [NACC-1:0][ACC_W-1:0] acc_q, acc_d, acc_shr;
  logic [NACC-1:0]            lo_q, lo_d;
  logic [NACC-1:0][EXP_W-1:0] sh;

  logic                 fit_ph2_q;
  logic [NACC-1:0]      fit_mask_q, fit_mask_d;
  logic [EXP_W-1:0]     fit_sh_q, fit_sh_d, sh_joint;
  logic                 lane_ptr_q;

  logic [NLANE-1:0]             lane_busy, lane_done, lane_acc;
  logic [NLANE-1:0][ACC_W-1:0]  lane_prod;

  assign op     = mac_op_e'(cmd_op_i);
  assign is_mac = (op == OP_MAC_A) || (op == OP_MAC_B);
  assign is_rd  = (op == OP_RD_A)  || (op == OP_RD_B);
  assign is_fit = (op == OP_FIT_A) || (op == OP_FIT_B) || (op == OP_FIT_AB);
  assign rd_sel = (op == OP_RD_B);

  assign mac_inflight = |lane_busy;
  assign stall_o = cmd_valid_i && (op != OP_NOP) &&
                   (fit_ph2_q || (mac_inflight && !is_mac));
  assign busy_o  = fit_ph2_q || mac_inflight;
  assign take    = cmd_valid_i && !stall_o;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    mac_dual_acc_lane #(.DW(DW), .MUL_W(MUL_W), .ACC_W(ACC_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (take && is_mac && (lane_ptr_q == 1'(l))),
      .a_i    (opd_a_i),
      .b_i    (opd_b_i),
      .sel_i  (op == OP_MAC_B),
      .busy_o (lane_busy[l]),
      .done_o (lane_done[l]),
      .sel_o  (lane_acc[l]),
      .prod_o (lane_prod[l])
    );
  end

  for (genvar k = 0; k < NACC; k++) begin : g_fit
    mac_dual_acc_fit #(.DW(DW), .ACC_W(ACC_W), .EXP_W(EXP_W)) u_fit (
      .acc_i   (acc_q[k]),
      .shamt_o (sh[k])
    );
    assign acc_shr[k] = ACC_W'($signed(acc_q[k]) >>> fit_sh_q);
  end

  assign sh_joint = (sh[0] > sh[1]) ? sh[0] : sh[1];

  always_comb begin
    fit_mask_d = 2'b11;
    fit_sh_d   = sh_joint;
    if (op == OP_FIT_A) begin
      fit_mask_d = 2'b01;
      fit_sh_d   = sh[0];
    end else if (op == OP_FIT_B) begin
      fit_mask_d = 2'b10;
      fit_sh_d   = sh[1];
    end
  end

  always_comb begin
    acc_d = acc_q;
    lo_d  = lo_q;
    for (int l = 0; l < NLANE; l++) begin
      if (lane_done[l]) begin
        acc_d[lane_acc[l]] = acc_d[lane_acc[l]] + lane_prod[l];
        lo_d[lane_acc[l]]  = 1'b0;
      end
    end
    if (fit_ph2_q) begin
      for (int k = 0; k < NACC; k++) begin
        if (fit_mask_q[k]) begin
          acc_d[k] = {DW'(fit_sh_q), acc_shr[k][DW-1:0]};
          lo_d[k]  = 1'b0;
        end
      end
    end
    if (take) begin
      unique case (op)
        OP_CLR_A:  begin acc_d[0] = '0; lo_d[0] = 1'b0; end
        OP_CLR_B:  begin acc_d[1] = '0; lo_d[1] = 1'b0; end
        OP_CLR_AB: begin acc_d = '0; lo_d = '0; end
        OP_SET_A:  begin acc_d[0] = {opd_b_i, opd_a_i}; lo_d[0] = 1'b0; end
        OP_SET_B:  begin acc_d[1] = {opd_b_i, opd_a_i}; lo_d[1] = 1'b0; end
        OP_RD_A:   lo_d[0] = 1'b1;
        OP_RD_B:   lo_d[1] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= '0;
      lo_q       <= '0;
      fit_ph2_q  <= 1'b0;
      fit_mask_q <= '0;
      fit_sh_q   <= '0;
      lane_ptr_q <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      lo_q      <= lo_d;
      fit_ph2_q <= take && is_fit;
      if (take && is_fit) begin
        fit_mask_q <= fit_mask_d;
        fit_sh_q   <= fit_sh_d;
      end
      if (take && is_mac) lane_ptr_q <= ~lane_ptr_q;
    end
  end

  assign rd_valid_o = take && is_rd;
  assign rd_data_o  = lo_q[rd_sel] ? acc_q[rd_sel][ACC_W-1:DW] : acc_q[rd_sel][DW-1:0];
endmodule

// File: rtl/mac_dual_acc_chk.sv
module mac_dual_acc_chk
  import mac_dual_acc_pkg::*;
#(
  parameter int DW = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_i,
  input logic [3:0]      cmd_op_i,
  input logic            stall_o,
  input logic            busy_o,
  input logic            rd_valid_o,
  input logic            fit_busy_i,
  input logic [2*DW-1:0] acc_a_i,
  input logic [2*DW-1:0] acc_b_i
);
  logic is_mac, is_rd, is_fit, take;
  assign is_mac = (cmd_op_i == OP_MAC_A) || (cmd_op_i == OP_MAC_B);
  assign is_rd  = (cmd_op_i == OP_RD_A)  || (cmd_op_i == OP_RD_B);
  assign is_fit = (cmd_op_i == OP_FIT_A) || (cmd_op_i == OP_FIT_B) || (cmd_op_i == OP_FIT_AB);
  assign take   = cmd_valid_i && !stall_o;

  assert_mac_no_stall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && is_mac && !fit_busy_i) |-> !stall_o);

  assert_rd_after_mac_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && is_mac) |=> (!(cmd_valid_i && is_rd) || stall_o));

  assert_fit_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && is_fit) |=> (!(cmd_valid_i && (cmd_op_i != OP_NOP)) || stall_o));

  assert_clear_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (cmd_op_i == OP_CLR_A || cmd_op_i == OP_CLR_AB)) |=> (acc_a_i == '0));

  assert_clear_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && (cmd_op_i == OP_CLR_B || cmd_op_i == OP_CLR_AB)) |=> (acc_b_i == '0));

  assert_exp_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && cmd_op_i == OP_FIT_A) |=> ##1 (acc_a_i[2*DW-1:DW] <= DW));

  assert_rd_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !busy_o);
endmodule

bind mac_dual_acc mac_dual_acc_chk #(.DW(DW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .stall_o     (stall_o),
  .busy_o      (busy_o),
  .rd_valid_o  (rd_valid_o),
  .fit_busy_i  (fit_ph2_q),
  .acc_a_i     (acc_q[0]),
  .acc_b_i     (acc_q[1])
);

// File: tb/mac_dual_acc_bench.sv
module mac_dual_acc_bench;
  import mac_dual_acc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [31:0] opa, opb;
  logic        stall_o, busy_o, rd_valid_o;
  logic [31:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] m_acc[2];
  bit          m_lo[2];

  always #10 clk = ~clk;  // 20-unit period, 50 MHz at 1 ns units

  mac_dual_acc u_mac_dual_acc (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .opd_a_i(opa), .opd_b_i(opb), .stall_o(stall_o), .busy_o(busy_o),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int fit_amt(input logic [63:0] v);
    for (int s = 0; s <= 32; s++) begin
      longint t;
      t = $signed(v) >>> s;
      if (t >= -64'sd2147483648 && t <= 64'sd2147483647) return s;
    end
    return 32;
  endfunction

  function automatic logic [63:0] fit_val(input logic [63:0] v, input int s);
    longint t;
    t = $signed(v) >>> s;
    return {32'(s), t[31:0]};
  endfunction

  // reference model; effects land in issue order
  task automatic model(input mac_op_e op, input logic [31:0] a, input logic [31:0] b, input string tag);
    longint pa, pb;
    int s;
    pa = longint'($signed(a[19:0]));
    pb = longint'($signed(b[19:0]));
    case (op)
      OP_MAC_A:  begin m_acc[0] = m_acc[0] + 64'(pa * pb); m_lo[0] = 0; end
      OP_MAC_B:  begin m_acc[1] = m_acc[1] + 64'(pa * pb); m_lo[1] = 0; end
      OP_CLR_A:  begin m_acc[0] = 0; m_lo[0] = 0; end
      OP_CLR_B:  begin m_acc[1] = 0; m_lo[1] = 0; end
      OP_CLR_AB: begin m_acc[0] = 0; m_acc[1] = 0; m_lo[0] = 0; m_lo[1] = 0; end
      OP_SET_A:  begin m_acc[0] = {b, a}; m_lo[0] = 0; end
      OP_SET_B:  begin m_acc[1] = {b, a}; m_lo[1] = 0; end
      OP_FIT_A:  begin m_acc[0] = fit_val(m_acc[0], fit_amt(m_acc[0])); m_lo[0] = 0; end
      OP_FIT_B:  begin m_acc[1] = fit_val(m_acc[1], fit_amt(m_acc[1])); m_lo[1] = 0; end
      OP_FIT_AB: begin
        s = fit_amt(m_acc[0]);
        if (fit_amt(m_acc[1]) > s) s = fit_amt(m_acc[1]);
        m_acc[0] = fit_val(m_acc[0], s);
        m_acc[1] = fit_val(m_acc[1], s);
        m_lo[0] = 0; m_lo[1] = 0;
      end
      OP_RD_A, OP_RD_B: begin
        int k;
        k = (op == OP_RD_B) ? 1 : 0;
        exp_q.push_back(m_lo[k] ? m_acc[k][63:32] : m_acc[k][31:0]);
        tag_q.push_back(tag);
        m_lo[k] = 1;
      end
      default: ;
    endcase
  endtask

  // driver: called at posedge+2, returns at posedge+2 after acceptance
  task automatic issue(input mac_op_e op, input logic [31:0] a, input logic [31:0] b,
                       input string tag, output int stalls);
    model(op, a, b, tag);
    stalls = 0;
    cmd_valid = 1'b1; cmd_op = op; opa = a; opb = b;
    @(negedge clk);
    while (stall_o) begin
      stalls++;
      @(negedge clk);
    end
    @(posedge clk); #2;
    cmd_valid = 1'b0; cmd_op = OP_NOP;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected read: actual %0h expected none", rd_data_o);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, "read data", rd_data_o, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int st;
    m_acc[0] = 0; m_acc[1] = 0; m_lo[0] = 0; m_lo[1] = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = OP_NOP; opa = 0; opb = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(1);

    // R4 reset state
    chk("R4", "busy after reset", busy_o, 0);
    chk("R4", "stall idle", stall_o, 0);
    issue(OP_RD_A, 0, 0, "R4", st);
    issue(OP_RD_A, 0, 0, "R4", st);
    issue(OP_RD_B, 0, 0, "R4", st);

    // R6 load, R10 low then high then high
    issue(OP_SET_A, 32'hdeadbeef, 32'h01234567, "R6", st);
    issue(OP_RD_A, 0, 0, "R6", st);
    issue(OP_RD_A, 0, 0, "R10", st);
    issue(OP_RD_A, 0, 0, "R10", st);

    // R2 with junk above bit 19; R10 flag cleared by MAC
    issue(OP_MAC_A, 32'hfff00003, 32'h000fffff, "R2", st);
    idle(2);
    issue(OP_RD_A, 0, 0, "R10", st);
    chk("R11", "read stalls after 2 idle", st, 0);
    issue(OP_RD_A, 0, 0, "R2", st);

    // R11 read right after MAC
    issue(OP_MAC_A, 32'h00080000, 32'h0007ffff, "R2", st);
    issue(OP_RD_A, 0, 0, "R11", st);
    chk("R11", "read stalls after MAC", st, 2);

    // R1 no-op after MAC
    issue(OP_MAC_B, 32'h12345, 32'h54321, "R2", st);
    issue(OP_NOP, 0, 0, "R1", st);
    chk("R1", "nop stalls", st, 0);
    idle(2);

    // R12 busy
    issue(OP_MAC_B, 32'h7, 32'h9, "R12", st);
    chk("R12", "busy cycle 1", busy_o, 1);
    idle(1);
    chk("R12", "busy cycle 2", busy_o, 1);
    idle(1);
    chk("R12", "busy cycle 3", busy_o, 0);

    // R3 back-to-back MACs
    for (int i = 0; i < 4; i++) begin
      issue(i[0] ? OP_MAC_B : OP_MAC_A, 32'h7ffff + i, 32'h80000 + i, "R3", st);
      chk("R3", "mac stalls", st, 0);
    end
    issue(OP_RD_B, 0, 0, "R3", st);
    issue(OP_RD_B, 0, 0, "R3", st);

    // R9 fit timing, R7 fit result
    issue(OP_SET_A, 32'h0, 32'h7fffffff, "R6", st);
    issue(OP_MAC_A, 32'h7ffff, 32'h7ffff, "R2", st);
    issue(OP_FIT_A, 0, 0, "R7", st);
    chk("R9", "fit stalls after MAC", st, 2);
    issue(OP_RD_A, 0, 0, "R7", st);
    chk("R9", "command after fit stalls", st, 1);
    issue(OP_RD_A, 0, 0, "R7", st);

    // R7 no shift needed: exponent zero
    issue(OP_SET_A, 32'hffffff80, 32'hffffffff, "R6", st);
    issue(OP_FIT_A, 0, 0, "R7", st);
    issue(OP_RD_A, 0, 0, "R7", st);
    issue(OP_RD_A, 0, 0, "R7", st);
    // R7 just past boundary: 0x80000000 needs shift 1
    issue(OP_SET_B, 32'h80000000, 32'h0, "R6", st);
    issue(OP_FIT_B, 0, 0, "R7", st);
    issue(OP_RD_B, 0, 0, "R7", st);
    issue(OP_RD_B, 0, 0, "R7", st);

    // R8 joint fit
    issue(OP_SET_A, 32'h34567890, 32'h00000012, "R6", st);
    issue(OP_SET_B, 32'h00000100, 32'h0, "R6", st);
    issue(OP_FIT_AB, 0, 0, "R8", st);
    issue(OP_RD_A, 0, 0, "R8", st);
    issue(OP_RD_A, 0, 0, "R8", st);
    issue(OP_RD_B, 0, 0, "R8", st);
    issue(OP_RD_B, 0, 0, "R8", st);

    // R5 clears
    issue(OP_SET_A, 32'h1, 32'h2, "R6", st);
    issue(OP_SET_B, 32'h3, 32'h4, "R6", st);
    issue(OP_CLR_B, 0, 0, "R5", st);
    issue(OP_RD_B, 0, 0, "R5", st);
    issue(OP_RD_A, 0, 0, "R5", st);
    issue(OP_CLR_A, 0, 0, "R5", st);
    issue(OP_RD_A, 0, 0, "R5", st);
    issue(OP_SET_B, 32'h5, 32'h6, "R6", st);
    issue(OP_CLR_AB, 0, 0, "R5", st);
    issue(OP_RD_A, 0, 0, "R5", st);
    issue(OP_RD_B, 0, 0, "R5", st);
    issue(OP_RD_B, 0, 0, "R5", st);

    // R2/R3 random streams
    void'($urandom(32'h5eed));
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom(); rb = $urandom();
      issue(($urandom() % 2) ? OP_MAC_B : OP_MAC_A, ra, rb, "R2", st);
      if (($urandom() % 8) == 0) idle(1);
      if ((i % 100) == 99) begin
        issue(OP_RD_A, 0, 0, "R2", st);
        issue(OP_RD_A, 0, 0, "R2", st);
        issue(OP_RD_B, 0, 0, "R2", st);
        issue(OP_RD_B, 0, 0, "R2", st);
        issue(OP_FIT_AB, 0, 0, "R8", st);
        issue(OP_RD_A, 0, 0, "R8", st);
        issue(OP_RD_A, 0, 0, "R8", st);
        issue(OP_RD_B, 0, 0, "R8", st);
        issue(OP_RD_B, 0, 0, "R8", st);
      end
    end

    idle(3);
    chk("R11", "reads outstanding", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule